// File: doc/BRIEF.md
# Multi-Event Trigger Busy Controller

This block sits between an external trigger line and a set of channel processors that buffer digitised events on the board. It brings the asynchronous trigger into the logic clock domain and turns each rising edge into one event. While the on-board buffer still has room, every such event is accepted: the event count goes up by one, and a single-cycle conversion start is sent to the channel processors.

When the count reaches the buffer's event limit, the block raises busy, which vetoes all further triggers. It also raises an interrupt request so that the readout CPU drains the buffers. Triggers that arrive while busy are dropped and tallied in a saturating rejected-trigger counter. After readout, software issues a one-cycle clear command. That command drops busy, the interrupt request and the event count together. The rejected tally is cumulative and only the chip reset clears it.

Top module: `evt_busy_ctrl`

## Requirements
- R1: The trigger input passes through a SYNC_STAGES-deep synchronizer. Each rising edge yields exactly one event, however long the trigger stays high. An accepted edge produces a conv_start pulse that is exactly one cycle wide, SYNC_STAGES+1 clock edges after the edge on which trig_in is first sampled high.
- R2: evt_count rises by exactly one on each accepted trigger, in the same cycle as conv_start, and never exceeds MAX_EVENTS (MAX_EVENTS is at least 2).
- R3: busy and irq both go high on the clock edge where evt_count reaches MAX_EVENTS.
- R4: While busy is high, a trigger edge produces no conv_start and leaves evt_count unchanged.
- R5: Each trigger edge that arrives while busy adds one to rej_count. rej_count saturates at all ones, and the clear command does not reset it.
- R6: Once irq is raised, it stays high until a clear command is received.
- R7: A clear command (sw_clear high for one cycle) makes busy, irq and evt_count all zero on the next clock edge.
- R8: Acceptance depends on busy in the cycle the edge is detected. If a trigger edge meets a clear while not busy, the count restarts at one and conv_start fires. If it meets a clear while busy, the edge is rejected and the count ends at zero.
- R9: After reset, busy, irq, conv_start, evt_count and rej_count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_in | input | 1 | Asynchronous trigger line |
| sw_clear | input | 1 | One-cycle clear command issued after readout |
| conv_start | output | 1 | One-cycle conversion start per accepted trigger |
| busy | output | 1 | Buffer full; triggers are vetoed |
| irq | output | 1 | Interrupt request to the readout CPU |
| evt_count | output | $clog2(MAX_EVENTS+1) | Number of events buffered |
| rej_count | output | REJ_W | Saturating count of triggers dropped while busy |

## Verification
The bench builds the block with MAX_EVENTS set to 3 and REJ_W set to 2, keeping SYNC_STAGES at 2. A three-event limit means the buffer fills after a few trigger pulses. A two-bit rejected counter hits saturation after only three dropped triggers, so a short run covers both the full-buffer veto and the counter's ceiling. The clear command is placed on the exact cycle that a trigger edge is detected, once while open and once while busy, to pin down the ordering rule.

// File: rtl/evt_busy_pkg.sv
package evt_busy_pkg;
  typedef enum logic {
    FILL_OPEN = 1'b0,
    FILL_FULL = 1'b1
  } fill_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/evt_fill_ctrl.sv
module evt_fill_ctrl
  import evt_busy_pkg::*;
#(
  parameter int MAX_EVENTS = 5,
  parameter int CNT_W      = $clog2(MAX_EVENTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             clear_i,
  output logic             start_o,
  output logic             reject_o,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_EVENTS);

  fill_e            state_q, state_d;
  logic [CNT_W-1:0] count_q, count_d, base;
  logic             count_en;
  logic             irq_q, irq_d;
  logic             start_q, start_d;
  logic             accept;

  always_comb begin
    accept   = rise_i & (state_q == FILL_OPEN);
    reject_o = rise_i & (state_q == FILL_FULL);
    base     = clear_i ? '0 : count_q;
    count_d  = accept ? base + 1'b1 : base;
    count_en = clear_i | accept;
    start_d  = accept;
    state_d  = state_q;
    irq_d    = irq_q;
    if (clear_i) begin
      state_d = FILL_OPEN;
      irq_d   = 1'b0;
    end
    if (accept && (count_d == LIMIT)) begin
      state_d = FILL_FULL;
      irq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_OPEN;
      count_q <= '0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      start_q <= start_d;
      if (count_en) count_q <= count_d;
    end
  end

  assign start_o = start_q;
  assign count_o = count_q;
  assign busy_o  = (state_q == FILL_FULL);
  assign irq_o   = irq_q;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         en;

  always_comb begin
    en  = inc_i & ~(&q_q);
    q_d = q_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/evt_busy_ctrl.sv
module evt_busy_ctrl #(
  parameter int MAX_EVENTS  = 5,
  parameter int SYNC_STAGES = 2,
  parameter int REJ_W       = 16,
  localparam int CNT_W      = $clog2(MAX_EVENTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             sw_clear,
  output logic             conv_start,
  output logic             busy,
  output logic             irq,
  output logic [CNT_W-1:0] evt_count,
  output logic [REJ_W-1:0] rej_count
);
  logic trig_rise;
  logic trig_reject;

  trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise_o   (trig_rise)
  );

  evt_fill_ctrl #(.MAX_EVENTS(MAX_EVENTS), .CNT_W(CNT_W)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (trig_rise),
    .clear_i  (sw_clear),
    .start_o  (conv_start),
    .reject_o (trig_reject),
    .count_o  (evt_count),
    .busy_o   (busy),
    .irq_o    (irq)
  );

  sat_counter #(.W(REJ_W)) u_rej (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (trig_reject),
    .q_o   (rej_count)
  );
endmodule

// File: rtl/evt_busy_ctrl_chk.sv
module evt_busy_ctrl_chk #(
  parameter int MAX_EVENTS = 5,
  parameter int REJ_W      = 16,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_clear,
  input logic             conv_start,
  input logic             busy,
  input logic             irq,
  input logic [CNT_W-1:0] evt_count,
  input logic [REJ_W-1:0] rej_count
);
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_count <= CNT_W'(MAX_EVENTS)); // R2

  AST_START_STEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && !$past(sw_clear) |-> evt_count == CNT_W'($past(evt_count) + 1'b1)); // R2

  AST_FULL_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_count == CNT_W'(MAX_EVENTS) |-> busy && irq); // R3

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !conv_start); // R4

  AST_REJ_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    rej_count != $past(rej_count) |-> rej_count == REJ_W'($past(rej_count) + 1'b1)); // R5

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !sw_clear |=> irq); // R6

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> !irq && !busy); // R7

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R1
endmodule

bind evt_busy_ctrl evt_busy_ctrl_chk #(
  .MAX_EVENTS (MAX_EVENTS),
  .REJ_W      (REJ_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_clear   (sw_clear),
  .conv_start (conv_start),
  .busy       (busy),
  .irq        (irq),
  .evt_count  (evt_count),
  .rej_count  (rej_count)
);

// File: tb/test_evt_busy_ctrl.sv
module test_evt_busy_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXE       = 3;
  localparam int REJW       = 2;
  localparam int CW         = $clog2(MAXE + 1);
  localparam int REJ_MAX    = (1 << REJW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_in = 1'b0;
  logic          sw_clear = 1'b0;
  logic          conv_start;
  logic          busy;
  logic          irq;
  logic [CW-1:0] evt_count;
  logic [REJW-1:0] rej_count;

  evt_busy_ctrl #(.MAX_EVENTS(MAXE), .SYNC_STAGES(2), .REJ_W(REJW)) i_evt_busy_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_in    (trig_in),
    .sw_clear   (sw_clear),
    .conv_start (conv_start),
    .busy       (busy),
    .irq        (irq),
    .evt_count  (evt_count),
    .rej_count  (rej_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int m_cnt = 0;
  bit m_busy = 1'b0;
  int m_rej = 0;
  bit prev_start = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model decision for one trigger edge seen with the current model state
  task automatic model_edge(input bit with_clear);
    if (!m_busy) begin
      if (with_clear) m_cnt = 0;
      m_cnt++;
      exp_q.push_back(m_cnt);
      if (m_cnt == MAXE) m_busy = 1'b1;
    end else begin
      if (m_rej < REJ_MAX) m_rej++;
      if (with_clear) begin
        m_cnt  = 0;
        m_busy = 1'b0;
      end
    end
  endtask

  task automatic pulse(input int width);
    model_edge(1'b0);
    @(negedge clk) trig_in = 1'b1;
    repeat (width) @(negedge clk);
    trig_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_cmd();
    @(negedge clk) sw_clear = 1'b1;
    @(negedge clk) sw_clear = 1'b0;
    m_cnt  = 0;
    m_busy = 1'b0;
  endtask

  // trigger edge detected on the same clock edge as the clear command
  task automatic clear_with_edge();
    model_edge(1'b1);
    @(negedge clk) trig_in = 1'b1;
    @(negedge clk);
    @(negedge clk) sw_clear = 1'b1;
    @(negedge clk) begin
      sw_clear = 1'b0;
      trig_in  = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_state(input string req);
    chk({req, " evt_count"}, int'(evt_count), m_cnt);
    chk({req, " busy"}, int'(busy), int'(m_busy));
    chk({req, " rej_count"}, int'(rej_count), m_rej);
  endtask

  // monitor: scoreboard of conversion starts
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (conv_start) begin
        if (prev_start) chk("R1 start width", 2, 1);
        if (exp_q.size() == 0) begin
          chk("R4 unexpected conv_start", 1, 0);
        end else begin
          chk("R2 count at start", int'(evt_count), exp_q.pop_front());
        end
      end
      prev_start = conv_start;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", int'(busy), 0);
    chk("R9 irq", int'(irq), 0);
    chk("R9 conv_start", int'(conv_start), 0);
    chk("R9 evt_count", int'(evt_count), 0);
    chk("R9 rej_count", int'(rej_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 latency: start appears SYNC_STAGES+1 edges after first sampling
    model_edge(1'b0);
    @(negedge clk) trig_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 no early start", int'(conv_start), 0);
    @(negedge clk);
    chk("R1 start at latency", int'(conv_start), 1);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    check_state("R2 after first");

    // R1 long pulse counts once
    pulse(12);
    check_state("R1 long pulse");
    chk("R1 irq before limit", int'(irq), 0);

    // fill to limit
    pulse(2);
    check_state("R3 at limit");
    chk("R3 irq", int'(irq), 1);

    // R4/R5 rejected triggers, saturation
    for (int i = 0; i < 4; i++) begin
      pulse(3);
      check_state("R5 reject");
    end
    chk("R4 count held", int'(evt_count), MAXE);

    // R6 irq holds
    repeat (20) @(negedge clk);
    chk("R6 irq held", int'(irq), 1);

    // R7 clear
    clear_cmd();
    check_state("R7 clear");
    chk("R7 irq", int'(irq), 0);
    chk("R5 rej kept after clear", int'(rej_count), REJ_MAX);

    // R8 clear coinciding while open
    pulse(2);
    clear_with_edge();
    check_state("R8 open coincide");
    chk("R8 irq open", int'(irq), 0);

    // refill and coincide while busy
    pulse(2);
    pulse(2);
    chk("R3 busy again", int'(busy), 1);
    clear_with_edge();
    check_state("R8 busy coincide");
    chk("R8 irq busy", int'(irq), 0);

    // accepted again after clear
    pulse(2);
    check_state("R7 accept after clear");

    repeat (5) @(negedge clk);
    chk("R4 pending starts", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule